// File: doc/BRIEF.md
# Serial Interrupt Request Agent

This block is the peripheral end of a serial interrupt request link. Host interrupt requests from one device are carried over a single shared open-drain wire, clocked by the bus clock. The agent takes a vector of local request bits (sixteen numbered interrupt lines plus one system-management line). Each enabled request is signalled by pulling the wire low in the time slot that belongs to that source. The host frames the transfer: it opens the frame with a start pulse, the agent counts three-clock slots after it, and the host closes the frame with a stop pulse. The width of the stop pulse picks the mode for the next frame.

There are two modes. In continuous mode the agent only answers frames that the host starts. In quiet mode an agent with something pending may itself open a frame by pulling the idle wire low for one clock, and the host then completes the start pulse. Requests are latched, so a one-clock pulse on a request input is not lost. A latched request is reported in the next slot of its source and is then cleared. A second, separate output asks the host to restart a stopped bus clock: it pulls the clock-run control wire low for two clocks.

Top module: `sirq_agent`

## Requirements
- R1: After reset the agent is in continuous mode and drives neither the interrupt wire (`sirq_oe`=0) nor the clock-run wire (`clkrun_oe`=0).
- R2: A frame begins when the agent samples the interrupt wire low while idle. The first clock in which the wire is sampled high again is the start turnaround. Slot k (k = 0 .. 20) then takes the three clocks that begin 3k+1 clocks after that one, in the phases sample, recovery and turnaround. Slot k for k = 0..15 carries request bit k (interrupt line k), slot 16 carries bit 16 (system management), and slots 17 to 20 are never driven.
- R3: In the sample phase of a slot the agent drives low (`sirq_oe`=1, `sirq_out`=0) exactly when that source is pending. In the recovery phase it drives high (`sirq_oe`=1, `sirq_out`=1) only if it drove low in the sample phase. In the turnaround phase it releases the wire.
- R4: Only request bits 1, 6, 9, 10, 11, 12 and 16 are honoured. A request on any other bit is never reported in any slot.
- R5: A request bit that is high for a single clock is latched. It is reported in the next sample phase of its slot and cleared there, so the following frame does not repeat it unless it is requested again.
- R6: A request that is latched before its slot's sample phase begins is reported in the current frame. A request latched at or after that point waits for the next frame.
- R7: After the last slot the agent counts the clocks in which the host holds the wire low. A stop pulse two clocks wide selects quiet mode and one three clocks wide selects continuous mode. Any other width leaves the mode unchanged.
- R8: In quiet mode, when the agent is idle with a pending request and samples the wire high, it drives the wire low for exactly one clock. In continuous mode it never starts a frame.
- R9: When a request is pending and the clock-run wire is sampled high while the agent is armed, `clkrun_oe` is asserted for exactly two clocks. The agent is armed again only after it samples the clock-run wire low while not driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 17 | Local requests: bits 0..15 interrupt lines, bit 16 system management |
| sirq_in | input | 1 | Sampled level of the shared interrupt wire |
| sirq_oe | output | 1 | Agent drives the interrupt wire |
| sirq_out | output | 1 | Value driven when `sirq_oe` is high |
| clkrun_in | input | 1 | Sampled level of the clock-run wire |
| clkrun_oe | output | 1 | Agent pulls the clock-run wire low |

## Verification
The hardest condition to reach is a request that lands exactly on the clock edge that opens its own slot's sample phase: it is one cycle too late for the current frame but must not be lost. The bench plays the host wire cycle by cycle, so it can drop a one-clock request pulse in the sample phase of a chosen slot. It checks that the pulse shows up in the same frame when it targets a later slot and in the next frame when it targets the same or an earlier slot. Switching between the quiet and continuous modes is reached by ending frames with stop pulses of 1, 2, 3 and 4 clocks, and each width is followed by a check of whether the agent opens a frame on its own.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_SLOT,
        FR_STOP
    } fr_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } fr_phase_e;

endpackage

// File: rtl/sirq_pend_latch.sv
module sirq_pend_latch #(
    parameter int                 NUM_SRC  = 17,
    parameter logic [NUM_SRC-1:0] SRC_MASK = 17'h11E42,
    parameter int                 IDX_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] pend,
    output logic               any_pend
);

    logic [NUM_SRC-1:0] pend_d, pend_q;

    // one sticky bit per source; a new request wins over a clear in the same cycle
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic hit;
        assign hit       = clr_en && (clr_idx == IDX_W'(i));
        assign pend_d[i] = ((pend_q[i] & ~hit) | src_req[i]) & SRC_MASK[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend     = pend_q;
    assign any_pend = |pend_q;

endmodule

// File: rtl/sirq_frame_fsm.sv
module sirq_frame_fsm
    import sirq_pkg::*;
#(
    parameter int NUM_SRC     = 17,
    parameter int FRAME_SLOTS = 21,
    parameter int QUIET_STOP  = 2,
    parameter int CONT_STOP   = 3,
    parameter int SLOT_W      = $clog2(FRAME_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_in,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               any_pend,
    output logic               line_oe,
    output logic               line_out,
    output logic               clr_en,
    output logic [SLOT_W-1:0]  clr_idx
);

    localparam int EXT_W    = 1 << SLOT_W;
    localparam int STOP_MAX = ((QUIET_STOP > CONT_STOP) ? QUIET_STOP : CONT_STOP) + 1;
    localparam int CNT_W    = $clog2(STOP_MAX + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
    localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(STOP_MAX);

    typedef struct packed {
        fr_state_e         st;
        fr_phase_e         ph;
        logic [SLOT_W-1:0] slot;
        logic              drove;
        logic              oe;
        logic              out;
        logic [CNT_W-1:0]  stop_cnt;
        logic              quiet;
    } fsm_t;

    fsm_t n, q;
    logic [EXT_W-1:0]  pend_ext;
    logic [SLOT_W-1:0] nxt_slot;

    assign pend_ext = EXT_W'(pend);
    assign nxt_slot = q.slot + SLOT_W'(1);

    always_comb begin
        n       = q;
        n.oe    = 1'b0;
        n.out   = 1'b1;
        clr_en  = 1'b0;
        clr_idx = q.slot;
        unique case (q.st)
            FR_IDLE: begin
                if (!line_in) begin
                    n.st = FR_START;
                end else if (q.quiet && any_pend) begin
                    n.oe  = 1'b1;           // open a frame ourselves
                    n.out = 1'b0;
                end
            end
            FR_START: begin
                if (line_in) begin
                    n.st    = FR_SLOT;
                    n.ph    = PH_SAMPLE;
                    n.slot  = '0;
                    n.drove = pend_ext[0];
                    n.oe    = pend_ext[0];
                    n.out   = ~pend_ext[0];
                    clr_en  = pend_ext[0];
                    clr_idx = '0;
                end
            end
            FR_SLOT: begin
                case (q.ph)
                    PH_SAMPLE: begin
                        n.ph = PH_RECOVER;
                        if (q.drove) begin
                            n.oe  = 1'b1;   // recovery: actively pull high
                            n.out = 1'b1;
                        end
                    end
                    PH_RECOVER: begin
                        n.ph = PH_TURN;
                    end
                    PH_TURN: begin
                        if (q.slot == LAST_SLOT) begin
                            n.st       = FR_STOP;
                            n.stop_cnt = '0;
                        end else begin
                            n.slot  = nxt_slot;
                            n.ph    = PH_SAMPLE;
                            n.drove = pend_ext[nxt_slot];
                            n.oe    = pend_ext[nxt_slot];
                            n.out   = ~pend_ext[nxt_slot];
                            clr_en  = pend_ext[nxt_slot];
                            clr_idx = nxt_slot;
                        end
                    end
                    default: n.ph = PH_SAMPLE;
                endcase
            end
            FR_STOP: begin
                if (!line_in) begin
                    if (q.stop_cnt != CNT_SAT) n.stop_cnt = q.stop_cnt + CNT_W'(1);
                end else if (q.stop_cnt != '0) begin
                    if (q.stop_cnt == CNT_W'(QUIET_STOP))     n.quiet = 1'b1;
                    else if (q.stop_cnt == CNT_W'(CONT_STOP)) n.quiet = 1'b0;
                    n.st       = FR_IDLE;
                    n.stop_cnt = '0;
                end
            end
            default: n.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= FR_IDLE;
            q.ph       <= PH_SAMPLE;
            q.slot     <= '0;
            q.drove    <= 1'b0;
            q.oe       <= 1'b0;
            q.out      <= 1'b1;
            q.stop_cnt <= '0;
            q.quiet    <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign line_oe  = q.oe;
    assign line_out = q.out;

endmodule

// File: rtl/sirq_clkrun_req.sv
module sirq_clkrun_req #(
    parameter int PULSE_LEN = 2,
    parameter int PW        = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clkrun_in,
    input  logic any_pend,
    output logic clkrun_oe
);

    typedef struct packed {
        logic          oe;
        logic [PW-1:0] cnt;
        logic          done;
    } ckr_t;

    ckr_t n, q;

    always_comb begin
        n    = q;
        n.oe = 1'b0;
        if (q.cnt != '0) begin
            n.cnt = q.cnt - PW'(1);
            n.oe  = 1'b1;
        end else if (!q.oe && !q.done && any_pend && clkrun_in) begin
            n.cnt  = PW'(PULSE_LEN - 1);
            n.oe   = 1'b1;
            n.done = 1'b1;
        end else if (!q.oe && !clkrun_in) begin
            n.done = 1'b0;                 // clock seen running again: rearm
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.oe   <= 1'b0;
            q.cnt  <= '0;
            q.done <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign clkrun_oe = q.oe;

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent #(
    parameter int                 NUM_SRC      = 17,
    parameter logic [NUM_SRC-1:0] SRC_MASK     = 17'h11E42,
    parameter int                 FRAME_SLOTS  = 21,
    parameter int                 QUIET_STOP   = 2,
    parameter int                 CONT_STOP    = 3,
    parameter int                 CLKRUN_PULSE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               sirq_in,
    output logic               sirq_oe,
    output logic               sirq_out,
    input  logic               clkrun_in,
    output logic               clkrun_oe
);

    localparam int SLOT_W = $clog2(FRAME_SLOTS);

    logic [NUM_SRC-1:0] pend;
    logic               any_pend;
    logic               clr_en;
    logic [SLOT_W-1:0]  clr_idx;

    sirq_pend_latch #(
        .NUM_SRC  (NUM_SRC),
        .SRC_MASK (SRC_MASK),
        .IDX_W    (SLOT_W)
    ) i_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .pend     (pend),
        .any_pend (any_pend)
    );

    sirq_frame_fsm #(
        .NUM_SRC     (NUM_SRC),
        .FRAME_SLOTS (FRAME_SLOTS),
        .QUIET_STOP  (QUIET_STOP),
        .CONT_STOP   (CONT_STOP),
        .SLOT_W      (SLOT_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (sirq_in),
        .pend     (pend),
        .any_pend (any_pend),
        .line_oe  (sirq_oe),
        .line_out (sirq_out),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx)
    );

    sirq_clkrun_req #(
        .PULSE_LEN (CLKRUN_PULSE)
    ) i_ckr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clkrun_in (clkrun_in),
        .any_pend  (any_pend),
        .clkrun_oe (clkrun_oe)
    );

endmodule

// File: rtl/sirq_agent_checks.sv
module sirq_agent_checks (
    input logic clk,
    input logic rst_n,
    input logic sirq_oe,
    input logic sirq_out,
    input logic clkrun_oe
);

    assert_high_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && sirq_out) |-> $past(sirq_oe && !sirq_out));

    assert_release_after_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && sirq_out) |=> !sirq_oe);

    assert_low_single_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && !sirq_out) |=> !(sirq_oe && !sirq_out));

    assert_clkrun_two_clocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clkrun_oe) && clkrun_oe) |=> !clkrun_oe);

endmodule

bind sirq_agent sirq_agent_checks i_sirq_agent_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .sirq_oe   (sirq_oe),
    .sirq_out  (sirq_out),
    .clkrun_oe (clkrun_oe)
);

// File: tb/test_sirq_agent.sv
module test_sirq_agent;

    localparam logic [16:0] MASK = (17'd1 << 1) | (17'd1 << 6) | (17'd1 << 9) |
                                   (17'd1 << 10) | (17'd1 << 11) | (17'd1 << 12) |
                                   (17'd1 << 16);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] src_req = '0;
    logic        host_low = 1'b0;
    logic        ckr_host_low = 1'b1;
    logic        sirq_oe, sirq_out, clkrun_oe;
    logic        sirq_line, clkrun_line;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    assign sirq_line   = !(host_low || (sirq_oe && !sirq_out));
    assign clkrun_line = !(ckr_host_low || clkrun_oe);

    sirq_agent i_sirq_agent (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .sirq_in   (sirq_line),
        .sirq_oe   (sirq_oe),
        .sirq_out  (sirq_out),
        .clkrun_in (clkrun_line),
        .clkrun_oe (clkrun_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic pulse_req(input logic [16:0] m);
        @(negedge clk) src_req = m;
        @(negedge clk) src_req = '0;
    endtask

    task automatic host_start(input int len);
        @(negedge clk) host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
    endtask

    // walk the 21 slots; optional one-clock request in the sample phase of late_slot
    task automatic walk(input logic [20:0] em, input int late_idx, input int late_slot,
                        input string req);
        for (int k = 0; k < 21; k++) begin
            @(negedge clk);
            chk((sirq_oe == em[k]) && (!em[k] || !sirq_out), req,
                $sformatf("sample slot %0d oe", k), int'(sirq_oe), int'(em[k]));
            if (late_slot == k) src_req[late_idx] = 1'b1;
            @(negedge clk);
            src_req = '0;
            chk((sirq_oe == em[k]) && (!em[k] || sirq_out), "R3",
                $sformatf("recovery slot %0d oe", k), int'(sirq_oe), int'(em[k]));
            @(negedge clk);
            chk(!sirq_oe, "R3", $sformatf("turnaround slot %0d oe", k), int'(sirq_oe), 0);
        end
    endtask

    task automatic host_stop(input int len);
        @(negedge clk) host_low = 1'b1;
        repeat (len) @(negedge clk);
        host_low = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [20:0] em, input int stop_len, input string req);
        host_start(4);
        walk(em, 0, -1, req);
        host_stop(stop_len);
    endtask

    // expects quiet mode and an empty latch; returns with the frame finished
    task automatic quiet_start(input int bit_idx, input int stop_len);
        pulse_req(17'd1 << bit_idx);
        @(negedge clk);
        chk(sirq_oe && !sirq_out, "R8", "agent start drive", int'(sirq_oe), 1);
        host_low = 1'b1;
        @(negedge clk);
        chk(!sirq_oe && !sirq_line, "R8", "start drive one clock", int'(sirq_oe), 0);
        repeat (2) @(negedge clk);
        host_low = 1'b0;
        walk(21'd1 << bit_idx, 0, -1, "R2");
        host_stop(stop_len);
    endtask

    task automatic expect_no_start(input int cycles, input string req);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk(!sirq_oe && sirq_line, req, "no agent start", int'(sirq_oe), 0);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!sirq_oe, "R1", "reset sirq_oe", int'(sirq_oe), 0);
        chk(!clkrun_oe, "R1", "reset clkrun_oe", int'(clkrun_oe), 0);
        rst_n = 1'b1;

        // R1/R8: continuous after reset, pending request does not start a frame
        pulse_req(17'd1 << 1);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            chk(!sirq_oe && !clkrun_oe, "R1", "continuous idle", int'(sirq_oe), 0);
        end
        frame(21'd1 << 1, 3, "R5");

        // R2/R4/R5: walking single pulse over every source bit
        for (int i = 0; i < 17; i++) begin
            pulse_req(17'd1 << i);
            frame(21'(MASK & (17'd1 << i)), 3, "R4");
        end
        frame(21'd0, 3, "R5");

        // several patterns
        pulse_req('1);
        frame(21'(MASK), 3, "R4");
        pulse_req(17'h0AAAA);
        frame(21'(MASK & 17'h0AAAA), 3, "R2");
        pulse_req(17'h15555);
        frame(21'(MASK & 17'h15555), 3, "R2");

        // R6: late requests
        host_start(4);
        walk(21'd1 << 11, 11, 3, "R6");
        host_stop(3);
        host_start(4);
        walk(21'd0, 6, 6, "R6");
        host_stop(3);
        host_start(4);
        walk(21'd1 << 6, 1, 9, "R6");
        host_stop(3);
        frame(21'd1 << 1, 3, "R6");

        // R7/R8: stop width 2 -> quiet, agent opens a frame
        frame(21'd0, 2, "R7");
        expect_no_start(15, "R8");
        quiet_start(12, 2);
        // width 4 keeps quiet
        frame(21'd0, 4, "R7");
        quiet_start(16, 1);
        // width 1 keeps quiet, then width 3 -> continuous
        quiet_start(9, 3);
        pulse_req(17'd1 << 10);
        expect_no_start(15, "R7");
        frame(21'd1 << 10, 3, "R7");

        // R9: clock-run restart request
        ckr_host_low = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            chk(!clkrun_oe, "R9", "no request without pending", int'(clkrun_oe), 0);
        end
        pulse_req(17'd1 << 9);
        @(negedge clk);
        chk(clkrun_oe, "R9", "clkrun cycle 1", int'(clkrun_oe), 1);
        @(negedge clk);
        chk(clkrun_oe, "R9", "clkrun cycle 2", int'(clkrun_oe), 1);
        @(negedge clk);
        chk(!clkrun_oe, "R9", "clkrun released", int'(clkrun_oe), 0);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            chk(!clkrun_oe, "R9", "not rearmed", int'(clkrun_oe), 0);
        end
        ckr_host_low = 1'b1;
        @(negedge clk) ckr_host_low = 1'b0;
        @(negedge clk);
        chk(clkrun_oe, "R9", "rearmed cycle 1", int'(clkrun_oe), 1);
        @(negedge clk);
        chk(clkrun_oe, "R9", "rearmed cycle 2", int'(clkrun_oe), 1);
        @(negedge clk);
        chk(!clkrun_oe, "R9", "rearmed released", int'(clkrun_oe), 0);
        ckr_host_low = 1'b1;
        frame(21'd1 << 9, 3, "R9");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule